// File: doc/BRIEF.md
# RTC Shadow Register Access Controller

This block sits between a processor register bus running on a fast clock and a real-time counter running on a slow clock of roughly 500 Hz. It keeps a bus-side shadow copy of the counter's time value and of the two rate-trim fields (a 17-bit coarse trim P and a 2-bit fine trim Q). Software therefore always reads and writes a coherent multi-byte image, and never a value that the counter changes halfway through an access.

Two freeze bits steer the shadow. The read-freeze bit stops the per-tick refresh so that software can read every time byte from the same instant. The write-freeze bit opens the shadow for writing. Clearing it hands the new time and trim values to the counter side through a toggle-and-two-flop synchronizer. A toggle acknowledge comes back the same way, and only then does the write-freeze bit read back as 0. A sticky fail flag records counter errors reported by a hardware pulse. The counter itself lives outside the block: the block samples its time value, and it drives a load pulse with the value to load and the active trim settings.

Top module: `rtc_shadow_ctrl`

## Requirements
- R1: While the read-freeze bit (control byte at address 0, bit 0) is set and the write-freeze bit is clear, the shadow time bytes (addresses 4 to 7, least significant byte first) do not change.
- R2: Control bit 0 reads 1 while read-freeze is set. After read-freeze is cleared it keeps reading 1 until the next shadow refresh, then reads 0.
- R3: While the write-freeze bit (control bit 1) is set, bus writes to the time bytes and to the trim bytes (address 1 = P[7:0], address 2 = P[15:8], address 3 bit 0 = P[16] and bits 2:1 = Q) update the shadow, and the new values read back.
- R4: Writing 0 to control bit 1 while it is set requests a commit. After the request passes a two-flop synchronizer in the RTC domain, `ctr_load_o` is high for exactly one RTC cycle, and `ctr_time_o` then holds the shadow time value.
- R5: Control bit 1 reads 1 from the write that sets it until the commit acknowledge has crossed back into the bus domain, even after software has cleared it.
- R6: `trim_p_o` and `trim_q_o` change only in the RTC cycle where `ctr_load_o` rises, and they take the shadow trim values at that point.
- R7: The fail flag (control bit 2) is set by a one-cycle `err_i` pulse and cleared by writing 0 to bit 2. Writing 1 to bit 2 has no effect. When `err_i` and a clearing write occur in the same cycle, the flag ends up set.
- R8: After reset every control bit reads 0, the time shadow reads 0, and the trim reads P = 0x10000, Q = 0 on both the bus and the trim outputs.
- R9: When neither freeze bit is set and no commit is pending, the shadow time is refreshed from `ctr_time_i` on every RTC tick.
- R10: Bus writes to data bytes while the write-freeze bit is clear are ignored. A write of 1 to control bit 1 while a commit is still pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| rtc_clk | input | 1 | Slow RTC clock |
| rtc_rst | input | 1 | Synchronous active-high reset, RTC domain |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| err_i | input | 1 | Counter error pulse, bus domain |
| ctr_time_i | input | TIME_W | Current counter time, RTC domain |
| ctr_load_o | output | 1 | One-cycle load strobe to the counter |
| ctr_time_o | output | TIME_W | Time value to load |
| trim_p_o | output | 17 | Active coarse rate trim |
| trim_q_o | output | 2 | Active fine rate trim |

## Verification
A stuck pending flag shows up at once on the bus as a write-freeze bit that never returns to 0. It also shows up within one RTC tick as time bytes that stop following the counter. A lost or doubled synchronizer toggle shows up as a missing or repeated load strobe within three RTC cycles of the clearing write. A wrong stale or fail state is visible in the control byte on the very next bus read. A shadow corrupted outside a write window changes the read data at the next access to that byte. The reference model predicts every register byte and every counter-side output, and they are compared on every bus clock.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

    localparam int BYTE_W = 8;
    localparam int P_W    = 17;
    localparam int Q_W    = 2;

    // register byte addresses
    localparam int ADR_CTRL      = 0;
    localparam int ADR_TRIM_LO   = 1;
    localparam int ADR_TRIM_MID  = 2;
    localparam int ADR_TRIM_HI   = 3;
    localparam int ADR_TIME_BASE = 4;

    // control byte bit positions
    localparam int BIT_RD   = 0;
    localparam int BIT_WR   = 1;
    localparam int BIT_FAIL = 2;

    typedef struct packed {
        logic [P_W-1:0] p;
        logic [Q_W-1:0] q;
    } trim_t;

    typedef struct packed {
        logic rd;      // read-freeze request
        logic stale;   // shadow not refreshed since read-freeze was set
        logic wr;      // write-freeze request
        logic pend;    // commit issued, acknowledge outstanding
        logic fail;    // sticky counter error
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] ctrl_byte(ctrl_t c);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[BIT_RD]   = c.rd | c.stale;
        b[BIT_WR]   = c.wr | c.pend;
        b[BIT_FAIL] = c.fail;
        return b;
    endfunction

    function automatic logic [BYTE_W-1:0] trim_byte(trim_t t, int idx);
        logic [BYTE_W-1:0] b;
        b = '0;
        case (idx)
            0:       b = t.p[7:0];
            1:       b = t.p[15:8];
            default: b = {3'b000, t.q, t.p[16]};
        endcase
        return b;
    endfunction

    function automatic trim_t trim_merge(trim_t t, int idx, logic [BYTE_W-1:0] d);
        trim_t r;
        r = t;
        case (idx)
            0:       r.p[7:0]  = d;
            1:       r.p[15:8] = d;
            default: begin
                r.p[16] = d[0];
                r.q     = d[2:1];
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_shadow_tsync.sv
module rtc_shadow_tsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_i,
    output logic evt_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[LAST-1:0], tgl_i};
    end

    // one-cycle pulse per toggle seen after the synchronizing stages
    assign evt_o = chain_q[LAST] ^ chain_q[LAST-1];

endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
    import rtc_shadow_pkg::*;
#(
    parameter int             TIME_W  = 32,
    parameter int             ADDR_W  = 4,
    parameter logic [P_W-1:0] P_RESET = 17'h10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              err_i,
    input  logic              tick_evt_i,
    input  logic [TIME_W-1:0] cap_time_i,
    input  logic              ack_evt_i,
    output logic              req_tgl_o,
    output logic [TIME_W-1:0] sh_time_o,
    output trim_t             sh_trim_o
);
    localparam int TIME_BYTES = TIME_W / BYTE_W;

    ctrl_t                          ctl_q;
    trim_t                          trim_q;
    logic [TIME_BYTES-1:0][BYTE_W-1:0] time_q;
    logic                           req_q;
    logic                           refresh;
    logic                           ctrl_wr;

    assign refresh = tick_evt_i && !ctl_q.rd && !ctl_q.wr && !ctl_q.pend;
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            trim_q <= '{p: P_RESET, q: '0};
            time_q <= '0;
            req_q  <= 1'b0;
        end else begin
            if (refresh) begin
                time_q      <= cap_time_i;
                ctl_q.stale <= 1'b0;
            end
            if (ack_evt_i)
                ctl_q.pend <= 1'b0;

            // hardware error wins over a software clear
            if (err_i)
                ctl_q.fail <= 1'b1;
            else if (ctrl_wr && !bus_wdata[BIT_FAIL])
                ctl_q.fail <= 1'b0;

            if (ctrl_wr) begin
                ctl_q.rd <= bus_wdata[BIT_RD];
                if (bus_wdata[BIT_RD])
                    ctl_q.stale <= 1'b1;
                if (bus_wdata[BIT_WR]) begin
                    if (!ctl_q.pend)
                        ctl_q.wr <= 1'b1;
                end else if (ctl_q.wr) begin
                    ctl_q.wr   <= 1'b0;
                    ctl_q.pend <= 1'b1;
                    req_q      <= ~req_q;
                end
            end

            if (bus_wr && ctl_q.wr) begin
                if (bus_addr == ADDR_W'(ADR_TRIM_LO))
                    trim_q <= trim_merge(trim_q, 0, bus_wdata);
                if (bus_addr == ADDR_W'(ADR_TRIM_MID))
                    trim_q <= trim_merge(trim_q, 1, bus_wdata);
                if (bus_addr == ADDR_W'(ADR_TRIM_HI))
                    trim_q <= trim_merge(trim_q, 2, bus_wdata);
                for (int i = 0; i < TIME_BYTES; i++) begin
                    if (bus_addr == ADDR_W'(ADR_TIME_BASE + i))
                        time_q[i] <= bus_wdata;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADR_CTRL))     bus_rdata = ctrl_byte(ctl_q);
        if (bus_addr == ADDR_W'(ADR_TRIM_LO))  bus_rdata = trim_byte(trim_q, 0);
        if (bus_addr == ADDR_W'(ADR_TRIM_MID)) bus_rdata = trim_byte(trim_q, 1);
        if (bus_addr == ADDR_W'(ADR_TRIM_HI))  bus_rdata = trim_byte(trim_q, 2);
        for (int i = 0; i < TIME_BYTES; i++) begin
            if (bus_addr == ADDR_W'(ADR_TIME_BASE + i))
                bus_rdata = time_q[i];
        end
    end

    assign req_tgl_o = req_q;
    assign sh_time_o = time_q;
    assign sh_trim_o = trim_q;

    // R1: a read freeze without a write window keeps the time shadow still
    p_rd_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.rd && !ctl_q.wr) |=> $stable(time_q));

    // R5: dropping the write freeze always leaves a pending commit behind
    p_wr_pend_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_q.wr) |-> ctl_q.pend);

    // R7: an error pulse always leaves the flag set
    p_fail_set_r7: assert property (@(posedge clk) disable iff (rst)
        err_i |=> ctl_q.fail);

    // R10: trim shadow only moves inside a write window
    p_trim_guard_r10: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.wr |=> $stable(trim_q));

endmodule

// File: rtl/rtc_shadow_core.sv
module rtc_shadow_core
    import rtc_shadow_pkg::*;
#(
    parameter int             TIME_W  = 32,
    parameter logic [P_W-1:0] P_RESET = 17'h10000
) (
    input  logic              rtc_clk,
    input  logic              rtc_rst,
    input  logic [TIME_W-1:0] ctr_time_i,
    input  logic              req_evt_i,
    input  logic [TIME_W-1:0] sh_time_i,
    input  trim_t             sh_trim_i,
    output logic              tick_tgl_o,
    output logic [TIME_W-1:0] cap_time_o,
    output logic              ack_tgl_o,
    output logic              ctr_load_o,
    output logic [TIME_W-1:0] ctr_time_o,
    output trim_t             trim_o
);
    logic              tick_q;
    logic              ack_q;
    logic              load_q;
    logic [TIME_W-1:0] cap_q;
    logic [TIME_W-1:0] ld_time_q;
    trim_t             trim_q;

    always_ff @(posedge rtc_clk) begin
        if (rtc_rst) begin
            tick_q    <= 1'b0;
            ack_q     <= 1'b0;
            load_q    <= 1'b0;
            cap_q     <= '0;
            ld_time_q <= '0;
            trim_q    <= '{p: P_RESET, q: '0};
        end else begin
            tick_q <= ~tick_q;
            cap_q  <= ctr_time_i;
            load_q <= req_evt_i;
            if (req_evt_i) begin
                ld_time_q <= sh_time_i;
                trim_q    <= sh_trim_i;
                ack_q     <= ~ack_q;
            end
        end
    end

    assign tick_tgl_o = tick_q;
    assign cap_time_o = cap_q;
    assign ack_tgl_o  = ack_q;
    assign ctr_load_o = load_q;
    assign ctr_time_o = ld_time_q;
    assign trim_o     = trim_q;

    // R4: the load strobe lasts one RTC cycle
    p_load_pulse_r4: assert property (@(posedge rtc_clk) disable iff (rtc_rst)
        ctr_load_o |=> !ctr_load_o);

    // R6: the active trim moves only together with a load strobe
    p_trim_commit_r6: assert property (@(posedge rtc_clk) disable iff (rtc_rst)
        !$stable(trim_q) |-> ctr_load_o);

endmodule

// File: rtl/rtc_shadow_ctrl.sv
module rtc_shadow_ctrl
    import rtc_shadow_pkg::*;
#(
    parameter int             TIME_W      = 32,
    parameter int             ADDR_W      = 4,
    parameter int             SYNC_STAGES = 2,
    parameter logic [P_W-1:0] P_RESET     = 17'h10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rtc_clk,
    input  logic              rtc_rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              err_i,
    input  logic [TIME_W-1:0] ctr_time_i,
    output logic              ctr_load_o,
    output logic [TIME_W-1:0] ctr_time_o,
    output logic [16:0]       trim_p_o,
    output logic [1:0]        trim_q_o
);
    localparam int TIME_BYTES = TIME_W / BYTE_W;
    localparam int ADR_LAST   = ADR_TIME_BASE + TIME_BYTES - 1;

    initial begin
        if (TIME_W % BYTE_W != 0 || ADR_LAST >= (1 << ADDR_W))
            $error("rtc_shadow_ctrl: time width or address width out of range");
    end

    logic              tick_tgl, tick_evt;
    logic              req_tgl, req_evt;
    logic              ack_tgl, ack_evt;
    logic [TIME_W-1:0] cap_time;
    logic [TIME_W-1:0] sh_time;
    trim_t             sh_trim;
    trim_t             act_trim;

    rtc_shadow_regs #(.TIME_W(TIME_W), .ADDR_W(ADDR_W), .P_RESET(P_RESET)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .err_i      (err_i),
        .tick_evt_i (tick_evt),
        .cap_time_i (cap_time),
        .ack_evt_i  (ack_evt),
        .req_tgl_o  (req_tgl),
        .sh_time_o  (sh_time),
        .sh_trim_o  (sh_trim)
    );

    // RTC domain -> bus domain: tick and acknowledge
    rtc_shadow_tsync #(.STAGES(SYNC_STAGES)) u_tick_sync (
        .clk (clk), .rst (rst), .tgl_i (tick_tgl), .evt_o (tick_evt)
    );
    rtc_shadow_tsync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk), .rst (rst), .tgl_i (ack_tgl), .evt_o (ack_evt)
    );
    // bus domain -> RTC domain: commit request
    rtc_shadow_tsync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (rtc_clk), .rst (rtc_rst), .tgl_i (req_tgl), .evt_o (req_evt)
    );

    rtc_shadow_core #(.TIME_W(TIME_W), .P_RESET(P_RESET)) u_core (
        .rtc_clk    (rtc_clk),
        .rtc_rst    (rtc_rst),
        .ctr_time_i (ctr_time_i),
        .req_evt_i  (req_evt),
        .sh_time_i  (sh_time),
        .sh_trim_i  (sh_trim),
        .tick_tgl_o (tick_tgl),
        .cap_time_o (cap_time),
        .ack_tgl_o  (ack_tgl),
        .ctr_load_o (ctr_load_o),
        .ctr_time_o (ctr_time_o),
        .trim_o     (act_trim)
    );

    assign trim_p_o = act_trim.p;
    assign trim_q_o = act_trim.q;

endmodule

// File: tb/test_rtc_shadow_ctrl.sv
module test_rtc_shadow_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int RTC_HALF   = 35;
    localparam logic [16:0] P_RST = 17'h10000;

    logic        clk = 0, rtc_clk = 0, rst = 1, rtc_rst = 1;
    logic        bus_wr = 0, err_i = 0;
    logic [3:0]  bus_addr = 0;
    logic [7:0]  bus_wdata = 0, bus_rdata;
    logic [31:0] ctr_time_i, ctr_time_o;
    logic        ctr_load_o;
    logic [16:0] trim_p_o;
    logic [1:0]  trim_q_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    rtc_shadow_ctrl i_rtc_shadow_ctrl (
        .clk(clk), .rst(rst), .rtc_clk(rtc_clk), .rtc_rst(rtc_rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .err_i(err_i), .ctr_time_i(ctr_time_i),
        .ctr_load_o(ctr_load_o), .ctr_time_o(ctr_time_o),
        .trim_p_o(trim_p_o), .trim_q_o(trim_q_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    initial begin
        #2;
        forever begin rtc_clk = 1; #RTC_HALF; rtc_clk = 0; #RTC_HALF; end
    end

    // external counter: counts per RTC tick, loads on strobe
    logic [31:0] ext_cnt = 0;
    assign ctr_time_i = ext_cnt;
    always @(negedge rtc_clk) begin
        if (rtc_rst)         ext_cnt = 0;
        else if (ctr_load_o) ext_cnt = ctr_time_o;
        else                 ext_cnt = ext_cnt + 1;
    end

    // ---------------- reference model ----------------
    bit m_rd, m_stale, m_wr, m_pend, m_fail, m_req;
    bit [16:0] m_p;  bit [1:0] m_q;  bit [31:0] m_time;
    bit m_tick, m_ack, m_ld;  bit [31:0] m_cap, m_ldt;
    bit [16:0] m_tp; bit [1:0] m_tq;
    bit m_tkq[$], m_akq[$], m_rqq[$];

    always @(posedge clk) begin
        if (rst) begin
            {m_rd, m_stale, m_wr, m_pend, m_fail, m_req} = '0;
            m_p = P_RST; m_q = 0; m_time = 0;
            m_tkq = '{0, 0, 0}; m_akq = '{0, 0, 0};
        end else begin
            bit tev, aev, refresh, o_wr, o_pend;
            tev = m_tkq[1] ^ m_tkq[2];
            aev = m_akq[1] ^ m_akq[2];
            m_tkq.push_front(m_tick); void'(m_tkq.pop_back());
            m_akq.push_front(m_ack);  void'(m_akq.pop_back());
            refresh = tev && !m_rd && !m_wr && !m_pend;
            o_wr = m_wr; o_pend = m_pend;
            if (refresh) begin m_time = m_cap; m_stale = 0; end
            if (aev) m_pend = 0;
            if (err_i) m_fail = 1;
            else if (bus_wr && bus_addr == 0 && !bus_wdata[2]) m_fail = 0;
            if (bus_wr && bus_addr == 0) begin
                m_rd = bus_wdata[0];
                if (bus_wdata[0]) m_stale = 1;
                if (bus_wdata[1]) begin
                    if (!o_pend) m_wr = 1;
                end else if (o_wr) begin
                    m_wr = 0; m_pend = 1; m_req = !m_req;
                end
            end
            if (bus_wr && o_wr) begin
                case (bus_addr)
                    1: m_p[7:0] = bus_wdata;
                    2: m_p[15:8] = bus_wdata;
                    3: begin m_p[16] = bus_wdata[0]; m_q = bus_wdata[2:1]; end
                    4, 5, 6, 7: m_time[8*(bus_addr-4) +: 8] = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    always @(posedge rtc_clk) begin
        if (rtc_rst) begin
            m_tick = 0; m_ack = 0; m_ld = 0; m_cap = 0; m_ldt = 0;
            m_tp = P_RST; m_tq = 0; m_rqq = '{0, 0, 0};
        end else begin
            bit rev;
            rev = m_rqq[1] ^ m_rqq[2];
            m_rqq.push_front(m_req); void'(m_rqq.pop_back());
            m_tick = !m_tick;
            m_cap = ext_cnt;
            m_ld = rev;
            if (rev) begin m_ldt = m_time; m_tp = m_p; m_tq = m_q; m_ack = !m_ack; end
        end
    end

    function automatic logic [7:0] exp_rdata(int a);
        case (a)
            0: return {5'b0, m_fail, m_wr | m_pend, m_rd | m_stale};
            1: return m_p[7:0];
            2: return m_p[15:8];
            3: return {5'b0, m_q, m_p[16]};
            4, 5, 6, 7: return m_time[8*(a-4) +: 8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !rtc_rst && !done) begin
            string tag;
            logic [7:0] e;
            e = exp_rdata(int'(bus_addr));
            tag = (bus_addr == 0) ? "R2/R5/R7 ctrl" : (bus_addr < 4) ? "R3/R6 trim" : "R9 time";
            check(bus_rdata === e, tag, bus_rdata, e);
            check(ctr_load_o === m_ld, "R4 load", ctr_load_o, m_ld);
            check(ctr_time_o === m_ldt, "R4 load value", ctr_time_o, m_ldt);
            check(trim_p_o === m_tp && trim_q_o === m_tq, "R6 trim out",
                  {trim_q_o, trim_p_o}, {m_tq, m_tp});
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr_reg(input int a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = 4'(a); bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd_reg(input int a, output logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = 4'(a);
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic peek(output logic [7:0] d);
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v1, v2;
        int t;
        repeat (20) @(posedge clk);
        #1; rst = 0; rtc_rst = 0;

        // R8 reset state
        rd_reg(0, v); check(v == 8'h00, "R8 ctrl reset", v, 8'h00);
        rd_reg(3, v); check(v == 8'h01, "R8 trim hi reset", v, 8'h01);
        rd_reg(1, v); check(v == 8'h00, "R8 trim lo reset", v, 8'h00);
        check(trim_p_o == P_RST && trim_q_o == 0, "R8 trim out reset", trim_p_o, P_RST);

        // R9 refresh follows the counter
        idle(60);
        rd_reg(4, v1); idle(30); rd_reg(4, v2);
        check(v2 != v1, "R9 time refreshed", v2, v1 + 4);

        // R10 data write outside write window
        wr_reg(1, 8'hAA);
        rd_reg(1, v); check(v == 8'h00, "R10 write ignored", v, 8'h00);

        // R1 / R2 read freeze
        wr_reg(0, 8'h01);
        rd_reg(4, v1); idle(50); rd_reg(4, v2);
        check(v2 == v1, "R1 frozen time", v2, v1);
        rd_reg(0, v); check(v[0] == 1'b1, "R2 frozen status", v, 8'h01);
        wr_reg(0, 8'h00);
        peek(v); check(v[0] == 1'b1, "R2 stale after release", v, 8'h01);
        idle(30);
        rd_reg(0, v); check(v[0] == 1'b0, "R2 current after refresh", v, 8'h00);

        // R3 write window
        wr_reg(0, 8'h02);
        wr_reg(4, 8'h78); wr_reg(5, 8'h56); wr_reg(6, 8'h34); wr_reg(7, 8'h12);
        wr_reg(1, 8'h3F); wr_reg(2, 8'h00); wr_reg(3, 8'h05);
        rd_reg(4, v); check(v == 8'h78, "R3 time byte readback", v, 8'h78);
        rd_reg(3, v); check(v == 8'h05, "R3 trim hi readback", v, 8'h05);

        // R4 / R5 / R6 commit
        wr_reg(0, 8'h00);
        peek(v); check(v[1] == 1'b1, "R5 write bit after clear", v, 8'h02);
        check(trim_p_o == P_RST, "R6 trim unchanged before commit", trim_p_o, P_RST);
        wr_reg(0, 8'h02);   // pending: must be ignored (R10)
        t = 0;
        while (!ctr_load_o && t < 200) begin @(negedge clk); t++; end
        check(ctr_load_o == 1'b1, "R4 load strobe seen", ctr_load_o, 1);
        check(ctr_time_o == 32'h12345678, "R4 load value", ctr_time_o, 32'h12345678);
        check(bus_rdata[1] == 1'b1, "R5 still pending at load", bus_rdata, 8'h02);
        idle(10);
        check(trim_p_o == 17'h1003F && trim_q_o == 2'd2, "R6 trim committed",
              {trim_q_o, trim_p_o}, {2'd2, 17'h1003F});
        rd_reg(0, v); check(v == 8'h00, "R5 R10 released, re-set ignored", v, 8'h00);
        idle(100);
        rd_reg(7, v); check(v == 8'h12, "R9 refresh after commit", v, 8'h12);

        // R7 fail flag
        @(posedge clk); #1; err_i = 1; @(posedge clk); #1; err_i = 0;
        rd_reg(0, v); check(v[2] == 1'b1, "R7 set by error", v, 8'h04);
        wr_reg(0, 8'h04);
        rd_reg(0, v); check(v[2] == 1'b1, "R7 write 1 no effect", v, 8'h04);
        wr_reg(0, 8'h00);
        rd_reg(0, v); check(v[2] == 1'b0, "R7 cleared by write 0", v, 8'h00);
        @(posedge clk); #1; err_i = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 8'h00;
        @(posedge clk); #1; err_i = 0; bus_wr = 0;
        rd_reg(0, v); check(v[2] == 1'b1, "R7 set beats clear", v, 8'h04);
        wr_reg(0, 8'h00);

        // address sweep for the per-cycle model compare
        for (int a = 0; a < 10; a++) begin rd_reg(a, v); idle(3); end
        idle(20);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule